// File: doc/BRIEF.md
# Serial-Programmed Synthesiser Register Interface

This block is a two-wire serial bus target that loads the tuning registers of a frequency synthesiser. A bus controller addresses it, then writes bytes that set a 15-bit divider ratio, an 8-bit control word and a 4-bit port-enable field. It can also read back a status byte. SCL and SDA are oversampled on the system clock. SDA is open-drain: the block never drives it high, and `sda_oe_o` high means the line is pulled low.

In a write transfer, bit 7 of each data byte chooses its role. A byte with bit 7 clear carries the upper divider bits and is followed by the lower divider byte. A byte with bit 7 set is the control word and is followed by the port byte. Any number of such pairs may follow one address. In a read transfer the block sends the same status byte repeatedly for as long as the controller acknowledges. After a power-on the registers stay cleared, and writes are ignored, until a read transfer has been closed with a STOP.

Top module: `synth_prog_i2c`

## Requirements
- R1: The block responds only to the 7-bit address {5'b11000, addr_sel_i}, sent MSB first and followed by the R/W bit (0 = write, 1 = read). A non-matching address is not acknowledged, and the bytes that follow it until the next START have no effect.
- R2: The block pulls SDA low for the acknowledge clock after a matching address byte and after every data byte received in a write transfer.
- R3: A write data byte with bit 7 = 0 loads its bits 6:0 into div_ratio_o[14:8]. The byte after it loads div_ratio_o[7:0].
- R4: A write data byte with bit 7 = 1 loads all 8 bits into ctrl_o. The byte after it loads its bits 3:0 into port_en_o, where a 1 turns a port on and a 0 leaves it high impedance.
- R5: After a complete pair, the next byte in the same transfer is classified again by its bit 7, with no new address needed.
- R6: A register changes only when the eighth bit of a complete byte is received. A transfer that ends partway through a byte leaves that byte's register unchanged, and the next transfer starts with a first-of-pair byte.
- R7: In a read transfer each status byte is sent MSB first as {por_flag, lock_i, port_lvl_i[2] (P7), port_lvl_i[1] (P5), port_lvl_i[0] (P4), conv_code_i[2:0]}. A 1 releases SDA and a 0 pulls it low.
- R8: When the controller acknowledges a status byte, another status byte follows. When it does not, the block releases SDA and ignores all clocks until the next START.
- R9: The power-on flag is 1 after reset. It is cleared by a STOP that ends a read transfer, including one ended by a missing acknowledge, and it never sets again.
- R10: While the power-on flag is 1, div_ratio_o, ctrl_o and port_en_o are held at 0. Write data bytes are acknowledged but have no effect.
- R11: After reset, SDA is released and all register outputs are 0.
- R12: A repeated START, even one that arrives partway through a byte, restarts the address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | When high, pulls the data line low |
| addr_sel_i | input | 2 | Low two bits of the target address |
| lock_i | input | 1 | Loop lock indicator reported in the status byte |
| port_lvl_i | input | 3 | Sensed port levels: [2] P7, [1] P5, [0] P4 |
| conv_code_i | input | 3 | Converter code reported in the status byte |
| div_ratio_o | output | 15 | Programmed divider ratio |
| ctrl_o | output | 8 | Programmed control word |
| port_en_o | output | 4 | Port enables, 1 = on |

## Verification
The hardest state to reach from the ports is the target that has stopped responding after a read byte was not acknowledged. A second, related case is the power-on flag, which only clears when a STOP ends a read. To reach the first, the bench reads a status byte, answers with a NACK, and then clocks a further eight bits without a START. It expects to see the line stay high throughout. The power-on case is covered at the start of the run: a write made before any read must change nothing, and the status byte must show the flag set on the first read and cleared on the read after the STOP.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
  localparam int DIV_W    = 15;
  localparam int PORT_N   = 4;
  localparam int SEL_W    = 2;
  localparam logic [6-SEL_W:0] ADDR_HI = 5'b11000;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_WR, S_ACK_WAIT, S_ACK_SLOT, S_TX, S_TX_ACK, S_TX_LOAD
  } bus_st_e;

  typedef enum logic [1:0] {P_FIRST, P_FREQ, P_PORT} pair_e;
endpackage

// File: rtl/synth_line_cond.sv
module synth_line_cond #(
  parameter int SYNC_N = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o,
  output logic sda_o
);
  logic [SYNC_N-1:0] scl_sync_q, sda_sync_q;
  logic scl_p_q, sda_p_q;
  logic scl_s, sda_s;

  assign scl_s = scl_sync_q[SYNC_N-1];
  assign sda_s = sda_sync_q[SYNC_N-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sync_q <= '1;
      sda_sync_q <= '1;
      scl_p_q    <= 1'b1;
      sda_p_q    <= 1'b1;
    end else begin
      scl_sync_q <= {scl_sync_q[SYNC_N-2:0], scl_i};
      sda_sync_q <= {sda_sync_q[SYNC_N-2:0], sda_i};
      scl_p_q    <= scl_s;
      sda_p_q    <= sda_s;
    end
  end

  assign scl_rise_o = scl_s & ~scl_p_q;
  assign scl_fall_o = ~scl_s & scl_p_q;
  // data edges while clock stays high
  assign start_o    = scl_s & scl_p_q & sda_p_q & ~sda_s;
  assign stop_o     = scl_s & scl_p_q & ~sda_p_q & sda_s;
  assign sda_o      = sda_s;
endmodule

// File: rtl/synth_reg_bank.sv
module synth_reg_bank
  import synth_prog_pkg::*;
#(
  parameter int DW = DIV_W,
  parameter int PN = PORT_N
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pair_rst_i,
  input  logic          byte_v_i,
  input  logic [7:0]    byte_d_i,
  input  logic          por_clr_i,
  output logic          por_o,
  output logic [DW-1:0] div_o,
  output logic [7:0]    ctrl_o,
  output logic [PN-1:0] port_o
);
  localparam int HI_W = DW - 8;

  pair_e         ptr_q;
  logic          por_q;
  logic [DW-1:0] div_q;
  logic [7:0]    ctrl_q;
  logic [PN-1:0] port_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= P_FIRST;
      por_q  <= 1'b1;
      div_q  <= '0;
      ctrl_q <= '0;
      port_q <= '0;
    end else begin
      if (por_clr_i) por_q <= 1'b0;
      if (pair_rst_i) begin
        ptr_q <= P_FIRST;
      end else if (byte_v_i) begin
        unique case (ptr_q)
          P_FIRST: begin
            if (byte_d_i[7]) begin
              ptr_q <= P_PORT;
              if (!por_q) ctrl_q <= byte_d_i;
            end else begin
              ptr_q <= P_FREQ;
              if (!por_q) div_q[DW-1:8] <= byte_d_i[HI_W-1:0];
            end
          end
          P_FREQ: begin
            ptr_q <= P_FIRST;
            if (!por_q) div_q[7:0] <= byte_d_i;
          end
          default: begin
            ptr_q <= P_FIRST;
            if (!por_q) port_q <= byte_d_i[PN-1:0];
          end
        endcase
      end
    end
  end

  assign por_o  = por_q;
  assign div_o  = div_q;
  assign ctrl_o = ctrl_q;
  assign port_o = port_q;

  AST_POR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_q |-> (div_q == '0 && ctrl_q == '0 && port_q == '0)); // R10
  AST_POR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !por_q |=> !por_q); // R9
  AST_HOLD_NO_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_v_i |=> $stable({div_q, ctrl_q, port_q})); // R6
  AST_LOW_AFTER_FREQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_v_i && !pair_rst_i && ptr_q == P_FREQ && !por_q) |=> div_q[7:0] == $past(byte_d_i)); // R3
endmodule

// File: rtl/synth_prog_i2c.sv
module synth_prog_i2c
  import synth_prog_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  input  logic [SEL_W-1:0] addr_sel_i,
  input  logic             lock_i,
  input  logic [2:0]       port_lvl_i,
  input  logic [2:0]       conv_code_i,
  output logic [DIV_W-1:0] div_ratio_o,
  output logic [7:0]       ctrl_o,
  output logic [PORT_N-1:0] port_en_o
);
  logic scl_rise, scl_fall, start_det, stop_det, sda_s;
  logic por;

  synth_line_cond #(.SYNC_N(2)) u_line (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det), .sda_o(sda_s)
  );

  bus_st_e    state_q;
  logic [2:0] bit_q;
  logic [7:0] sh_q, tx_q;
  logic       rd_q, rd_xfer_q, sda_oe_q;
  logic       byte_v_q, pair_rst_q, por_clr_q;
  logic [7:0] status;

  assign status = {por, lock_i, port_lvl_i, conv_code_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      bit_q      <= '0;
      sh_q       <= '0;
      tx_q       <= '0;
      rd_q       <= 1'b0;
      rd_xfer_q  <= 1'b0;
      sda_oe_q   <= 1'b0;
      byte_v_q   <= 1'b0;
      pair_rst_q <= 1'b0;
      por_clr_q  <= 1'b0;
    end else begin
      byte_v_q   <= 1'b0;
      pair_rst_q <= 1'b0;
      por_clr_q  <= 1'b0;
      if (start_det) begin
        state_q   <= S_ADDR;
        bit_q     <= '0;
        sda_oe_q  <= 1'b0;
        rd_xfer_q <= 1'b0;
      end else if (stop_det) begin
        state_q   <= S_IDLE;
        sda_oe_q  <= 1'b0;
        por_clr_q <= rd_xfer_q;
        rd_xfer_q <= 1'b0;
      end else begin
        unique case (state_q)
          S_ADDR, S_WR: if (scl_rise) begin
            sh_q  <= {sh_q[6:0], sda_s};
            bit_q <= bit_q + 3'd1;
            if (bit_q == 3'd7) begin
              if (state_q == S_WR) begin
                byte_v_q <= 1'b1;
                state_q  <= S_ACK_WAIT;
              end else if (sh_q[6:0] == {ADDR_HI, addr_sel_i}) begin
                rd_q       <= sda_s;
                rd_xfer_q  <= sda_s;
                pair_rst_q <= 1'b1;
                state_q    <= S_ACK_WAIT;
              end else begin
                state_q <= S_IDLE;
              end
            end
          end
          S_ACK_WAIT: if (scl_fall) begin
            sda_oe_q <= 1'b1;
            state_q  <= S_ACK_SLOT;
          end
          S_ACK_SLOT, S_TX_LOAD: if (scl_fall) begin
            bit_q <= '0;
            if (rd_q) begin
              tx_q     <= status;
              sda_oe_q <= ~status[7];
              state_q  <= S_TX;
            end else begin
              sda_oe_q <= 1'b0;
              state_q  <= S_WR;
            end
          end
          S_TX: if (scl_fall) begin
            if (bit_q == 3'd7) begin
              sda_oe_q <= 1'b0;
              state_q  <= S_TX_ACK;
            end else begin
              bit_q    <= bit_q + 3'd1;
              tx_q     <= {tx_q[6:0], 1'b0};
              sda_oe_q <= ~tx_q[6];
            end
          end
          // released line at the sample point means no acknowledge: internal stop
          S_TX_ACK: if (scl_rise) state_q <= sda_s ? S_IDLE : S_TX_LOAD;
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o = sda_oe_q;

  synth_reg_bank #(.DW(DIV_W), .PN(PORT_N)) u_regs (
    .clk_i, .rst_ni,
    .pair_rst_i(pair_rst_q), .byte_v_i(byte_v_q), .byte_d_i(sh_q),
    .por_clr_i(por_clr_q), .por_o(por),
    .div_o(div_ratio_o), .ctrl_o(ctrl_o), .port_o(port_en_o)
  );

  AST_ACK_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_ACK_SLOT |-> sda_oe_o); // R2
  AST_IDLE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_IDLE |-> !sda_oe_o); // R8
  AST_TX_ONLY_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_TX |-> rd_q); // R7
  AST_START_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> (state_q == S_ADDR && !sda_oe_o)); // R12
endmodule

// File: tb/synth_prog_i2c_bench.sv
module synth_prog_i2c_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;
  localparam int NV = 6;
  localparam logic [7:0] ADDR_W = 8'hC4;
  localparam logic [7:0] ADDR_R = 8'hC5;
  localparam logic [7:0] ADDR_BAD = 8'hC0;

  localparam logic [7:0]  VB1 [NV] = '{8'h12, 8'h85, 8'h7F, 8'hFF, 8'h00, 8'h80};
  localparam logic [7:0]  VB2 [NV] = '{8'h34, 8'h0A, 8'hFF, 8'h05, 8'h01, 8'h00};
  localparam logic [14:0] EDIV [NV] = '{15'h1234, 15'h1234, 15'h7FFF, 15'h7FFF, 15'h0001, 15'h0001};
  localparam logic [7:0]  ECTL [NV] = '{8'h00, 8'h85, 8'h85, 8'hFF, 8'hFF, 8'h80};
  localparam logic [3:0]  EPRT [NV] = '{4'h0, 4'hA, 4'hA, 4'h5, 4'h5, 4'h0};

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, sda_bus;
  logic [1:0] addr_sel = 2'b10;
  logic lock = 1'b1;
  logic [2:0] port_lvl = 3'b101, conv = 3'b011;
  logic [14:0] div;
  logic [7:0] ctrl;
  logic [3:0] port_en;
  int checks = 0, errors = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  synth_prog_i2c u_synth_prog_i2c (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .addr_sel_i(addr_sel), .lock_i(lock), .port_lvl_i(port_lvl), .conv_code_i(conv),
    .div_ratio_o(div), .ctrl_o(ctrl), .port_en_o(port_en)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic quarter(); repeat (Q) @(negedge clk); endtask
  task automatic bus_start();
    sda_m = 1'b1; quarter(); scl_m = 1'b1; quarter(); sda_m = 1'b0; quarter(); scl_m = 1'b0; quarter();
  endtask
  task automatic bus_stop();
    sda_m = 1'b0; quarter(); scl_m = 1'b1; quarter(); sda_m = 1'b1; quarter();
  endtask
  task automatic send_bit(input logic b);
    sda_m = b; quarter(); scl_m = 1'b1; quarter(); quarter(); scl_m = 1'b0; quarter();
  endtask
  task automatic send_byte(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    sda_m = 1'b1; quarter(); scl_m = 1'b1; quarter(); ack = ~sda_bus; quarter(); scl_m = 1'b0; quarter();
  endtask
  task automatic recv_byte(input logic m_ack, output logic [7:0] d);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      quarter(); scl_m = 1'b1; quarter(); d = {d[6:0], sda_bus}; quarter(); scl_m = 1'b0;
    end
    sda_m = ~m_ack; quarter(); scl_m = 1'b1; quarter(); quarter(); scl_m = 1'b0; quarter(); sda_m = 1'b1;
  endtask

  initial begin
    logic ack;
    logic [7:0] rd;
    repeat (5) @(negedge clk);
    check("R11 sda released in reset", {31'd0, sda_oe}, 32'd0);
    rst_n = 1'b1;
    quarter();
    check("R11 outputs zero after reset", {5'd0, div, ctrl, port_en}, 32'd0);

    // write before power-on flag cleared
    bus_start();
    send_byte(ADDR_W, ack); check("R1 R2 address ack", {31'd0, ack}, 32'd1);
    send_byte(8'h12, ack);  check("R2 data ack", {31'd0, ack}, 32'd1);
    send_byte(8'h34, ack);  check("R10 data ack while flag set", {31'd0, ack}, 32'd1);
    bus_stop();
    check("R10 write ignored while flag set", {5'd0, div, ctrl, port_en}, 32'd0);

    // status read with flag set, repeated, then NACK
    bus_start();
    send_byte(ADDR_R, ack); check("R1 read address ack", {31'd0, ack}, 32'd1);
    recv_byte(1'b1, rd);    check("R7 status byte", {24'd0, rd}, 32'hEB);
    recv_byte(1'b0, rd);    check("R8 second status byte after ack", {24'd0, rd}, 32'hEB);
    quarter();
    check("R8 released after nack", {31'd0, sda_oe}, 32'd0);
    recv_byte(1'b0, rd);    check("R8 silent after nack", {24'd0, rd}, 32'hFF);
    bus_stop();

    lock = 1'b0; port_lvl = 3'b010; conv = 3'b100;
    bus_start();
    send_byte(ADDR_R, ack);
    recv_byte(1'b0, rd);    check("R9 flag cleared by stop after read", {24'd0, rd}, 32'h14);
    bus_stop();

    // wrong address
    bus_start();
    send_byte(ADDR_BAD, ack); check("R1 no ack for other address", {31'd0, ack}, 32'd0);
    send_byte(8'h12, ack);    check("R1 no ack for following byte", {31'd0, ack}, 32'd0);
    send_byte(8'h34, ack);
    bus_stop();
    check("R1 registers untouched", {5'd0, div, ctrl, port_en}, 32'd0);

    // vector table, one pair per transfer
    for (int v = 0; v < NV; v++) begin
      bus_start();
      send_byte(ADDR_W, ack);
      send_byte(VB1[v], ack);
      send_byte(VB2[v], ack); check("R2 pair second byte ack", {31'd0, ack}, 32'd1);
      bus_stop();
      check("R3 divider from table", {17'd0, div}, {17'd0, EDIV[v]});
      check("R4 control from table", {24'd0, ctrl}, {24'd0, ECTL[v]});
      check("R4 ports from table", {28'd0, port_en}, {28'd0, EPRT[v]});
    end

    // several pairs in one transfer
    bus_start();
    send_byte(ADDR_W, ack);
    send_byte(8'h01, ack); send_byte(8'h02, ack);
    check("R5 first pair divider", {17'd0, div}, 32'h0102);
    send_byte(8'h83, ack); send_byte(8'h0C, ack);
    send_byte(8'h05, ack); send_byte(8'h06, ack);
    bus_stop();
    check("R5 divider after third pair", {17'd0, div}, 32'h0506);
    check("R5 control in second pair", {20'd0, ctrl, port_en}, 32'h83C);

    // stop partway through the low divider byte
    bus_start();
    send_byte(ADDR_W, ack);
    send_byte(8'h20, ack);
    check("R3 upper bits loaded alone", {17'd0, div}, 32'h2006);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    bus_stop();
    check("R6 partial byte keeps low bits", {17'd0, div}, 32'h2006);
    bus_start();
    send_byte(ADDR_W, ack);
    send_byte(8'hF0, ack); send_byte(8'h03, ack);
    bus_stop();
    check("R6 new transfer starts at first byte", {20'd0, ctrl, port_en}, 32'hF03);
    check("R6 divider unchanged", {17'd0, div}, 32'h2006);

    // repeated start inside a byte
    bus_start();
    send_byte(ADDR_W, ack);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    bus_start();
    send_byte(ADDR_W, ack); check("R12 ack after repeated start", {31'd0, ack}, 32'd1);
    send_byte(8'h11, ack); send_byte(8'h22, ack);
    bus_stop();
    check("R12 data after repeated start", {17'd0, div}, 32'h1122);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule